// File: doc/BRIEF.md
# Interrupt-Triggered Multi-Channel DMA Engine

This block sits between the raw interrupt request lines of a chip and its interrupt controller, and turns chosen interrupts into single memory-to-memory copies. Each of the eight channels is armed by writing a non-zero interrupt number into its trigger register. When that interrupt fires, the engine takes the request itself instead of letting it reach the interrupt controller. It reads one unit of 1, 2 or 4 bytes from the channel's source address and writes it to the channel's destination address. Then it steps both addresses and counts the channel's remaining transfers down by one.

When a channel's count runs out, it pulses its own completion interrupt and clears its trigger number, which disarms it. From then on, requests from that source go out as general interrupts. Requests from sources that no armed channel names are always forwarded this way, and they stay visible until the controller acknowledges them. A halt input freezes the start of new transfers while the processor is in standby.

Top module: `irq_dma_engine`

## Requirements
- R1: Each channel is configured through the register write port, where `reg_sel` picks the field: 0 trigger number, 1 source address, 2 destination address, 3 size code, 4 transfer count. A trigger number of 0 disarms the channel, so a request on source 0 never starts a transfer.
- R2: A request whose source is named by an armed channel is taken by the engine. Its pending flag is cleared and it never shows on `gen_irq`, which gives DMA service precedence over every maskable interrupt.
- R3: Each taken request makes exactly one read of the source followed by one write of the destination, and decrements the channel's count by one. Size code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes. `mem_addr` is the word address with bits [1:0] zero, and `mem_be` bit k marks byte lane k. The lanes start at address bits [1:0], and read lanes are realigned to the destination lanes.
- R4: When the count is not zero after the decrement, the channel stays armed, its trigger number is unchanged and no completion pulse is raised.
- R5: When the count reaches zero after the decrement, `tc_irq[ch]` pulses high for one cycle and the channel's trigger number becomes 0.
- R6: When several armed channels have pending requests, the lowest-numbered channel is served first.
- R7: While `halt` is high, no new transfer starts; pending requests stay pending and are served once `halt` falls.
- R8: A pending request whose source no armed channel names is driven on `gen_irq` until `irq_clr` for that source is pulsed. This includes a request that arrives in the same cycle its channel disarms.
- R9: After each unit, the source and destination addresses each advance by the number of bytes moved.
- R10: A register write to the channel being served is held back and takes effect when that transfer completes. The transfer in flight uses the old values.
- R11: A count of 0 acts as 65536 transfers, so a channel armed with count 0 keeps running and raises no completion pulse after a few units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Standby: blocks new transfers |
| irq_req | input | 32 | Raw interrupt lines, rising edge sets a pending flag |
| irq_clr | input | 32 | Acknowledge from the interrupt controller, clears forwarded flags |
| gen_irq | output | 32 | Forwarded general interrupt requests |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 3 | Channel to write |
| reg_sel | input | 3 | Field select (see R1) |
| reg_wdata | input | 32 | Write data |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| tc_irq | output | 8 | Per-channel completion pulse |

## Verification
The risky coincidence is a fresh edge on a channel's trigger source landing in the very cycle that channel's final write completes and it disarms. The bench waits for the acknowledge of that last write and raises the line at that moment. The new request must then appear on `gen_irq` with no second transfer, and the completion count must rise by exactly one. A second coincidence is a register write that reaches the channel being served. The bench writes a new destination while the read is outstanding and checks that this unit still lands at the old address and the next unit at the new one.

// File: rtl/irqdma_pkg.sv
package irqdma_pkg;

  typedef enum logic [2:0] {
    SEL_VEC  = 3'd0,
    SEL_SRC  = 3'd1,
    SEL_DST  = 3'd2,
    SEL_SIZE = 3'd3,
    SEL_CNT  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_e;

  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    unit_bytes = 3'd1;
      2'd1:    unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] unit_mask(input logic [1:0] code);
    case (code)
      2'd0:    unit_mask = 4'b0001;
      2'd1:    unit_mask = 4'b0011;
      default: unit_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/irqdma_pend.sv
module irqdma_pend #(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] dma_clr,
  input  logic [NIRQ-1:0] gen_clr,
  output logic [NIRQ-1:0] pend
);

  logic [NIRQ-1:0] irq_q;
  logic [NIRQ-1:0] rise;
  logic [NIRQ-1:0] pend_n;

  always_comb begin
    rise   = irq_req & ~irq_q;
    // a new edge wins over a clear in the same cycle
    pend_n = (pend & ~dma_clr & ~gen_clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_req;
      pend  <= pend_n;
    end
  end

  a_r2_taken_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dma_clr) && !(|(dma_clr & irq_req & ~irq_q))) |=> !(|(pend & $past(dma_clr))));

  a_r8_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_req & ~irq_q)) |=> (|(pend & $past(irq_req & ~irq_q))));

endmodule

// File: rtl/irqdma_arb.sv
module irqdma_arb #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt
);

  logic [NCH:0] lower_busy;

  assign lower_busy[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign gnt[i]          = req[i] & ~lower_busy[i];
    assign lower_busy[i+1] = lower_busy[i] | req[i];

    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> (req[i] && ((req & ((NCH'(1) << i) - NCH'(1))) == '0)));
  end

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

endmodule

// File: rtl/irqdma_chan.sv
module irqdma_chan
  import irqdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int VW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          done,
  output logic [VW-1:0] vec,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [1:0]    sz,
  output logic [CW-1:0] cnt,
  output logic          tc
);

  logic [VW-1:0] vec_n;
  logic [AW-1:0] src_n, dst_n;
  logic [1:0]    sz_n;
  logic [CW-1:0] cnt_n;
  logic          tc_n;
  logic [AW-1:0] step;

  assign step = AW'(unit_bytes(sz));

  always_comb begin
    vec_n = vec;
    src_n = src;
    dst_n = dst;
    sz_n  = sz;
    cnt_n = cnt;
    tc_n  = 1'b0;
    if (done) begin
      src_n = src + step;
      dst_n = dst + step;
      cnt_n = cnt - CW'(1);          // 0 wraps, so 0 means 65536 units
      if (cnt == CW'(1)) begin
        vec_n = '0;
        tc_n  = 1'b1;
      end
    end
    if (wr_en) begin                 // a deferred write lands on top of the update
      case (wr_sel)
        SEL_VEC:  vec_n = wr_data[VW-1:0];
        SEL_SRC:  src_n = wr_data;
        SEL_DST:  dst_n = wr_data;
        SEL_SIZE: sz_n  = wr_data[1:0];
        SEL_CNT:  cnt_n = wr_data[CW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec <= '0;
      src <= '0;
      dst <= '0;
      sz  <= '0;
      cnt <= '0;
      tc  <= 1'b0;
    end else begin
      vec <= vec_n;
      src <= src_n;
      dst <= dst_n;
      sz  <= sz_n;
      cnt <= cnt_n;
      tc  <= tc_n;
    end
  end

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en) |=> (cnt == $past(cnt) - CW'(1)));

  a_r4_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en && cnt != CW'(1)) |=> ($stable(vec) && !tc));

  a_r5_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en && cnt == CW'(1)) |=> (vec == '0 && tc));

  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en) |=> (src == $past(src) + AW'(unit_bytes($past(sz)))
                       && dst == $past(dst) + AW'(unit_bytes($past(sz)))));

endmodule

// File: rtl/irq_dma_engine.sv
module irq_dma_engine
  import irqdma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NIRQ = 32,
  parameter int AW   = 32,
  parameter int CW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    halt,
  input  logic [NIRQ-1:0]         irq_req,
  input  logic [NIRQ-1:0]         irq_clr,
  output logic [NIRQ-1:0]         gen_irq,
  input  logic                    reg_we,
  input  logic [$clog2(NCH)-1:0]  reg_ch,
  input  logic [2:0]              reg_sel,
  input  logic [AW-1:0]           reg_wdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [3:0]              mem_be,
  output logic [31:0]             mem_wdata,
  input  logic [31:0]             mem_rdata,
  input  logic                    mem_ack,
  output logic [NCH-1:0]          tc_irq
);

  localparam int VW  = $clog2(NIRQ);
  localparam int CHW = $clog2(NCH);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [VW-1:0]   vec_a [NCH];
  logic [AW-1:0]   src_a [NCH];
  logic [AW-1:0]   dst_a [NCH];
  logic [1:0]      sz_a  [NCH];
  logic [CW-1:0]   cnt_a [NCH];
  logic [2:0]      ch_sel [NCH];
  logic [AW-1:0]   ch_wd  [NCH];
  logic [NCH-1:0]  ch_req, gnt, ch_we, ch_done;
  logic [NIRQ-1:0] pend, claim, dma_clr;

  xfer_st_e        st, st_n;
  logic [CHW-1:0]  act_ch, act_ch_n, gnt_idx;
  logic [31:0]     data_q, data_n;
  logic            busy, accept, done;

  logic            dfr_v, dfr_v_n, queue, direct_we, dfr_apply;
  logic [CHW-1:0]  dfr_ch, dfr_ch_n;
  logic [2:0]      dfr_sel, dfr_sel_n;
  logic [AW-1:0]   dfr_data, dfr_data_n;

  irqdma_pend #(.NIRQ(NIRQ)) u_pend (
    .clk(clk), .rst_n(rst_i), .irq_req(irq_req),
    .dma_clr(dma_clr), .gen_clr(irq_clr), .pend(pend)
  );

  irqdma_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_i), .req(ch_req), .gnt(gnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic use_dfr;
    assign ch_req[c]  = (vec_a[c] != '0) && pend[vec_a[c]];
    assign ch_done[c] = done && (act_ch == CHW'(c));
    assign use_dfr    = dfr_apply && (dfr_ch == CHW'(c));
    assign ch_we[c]   = use_dfr || (direct_we && reg_ch == CHW'(c));
    assign ch_sel[c]  = use_dfr ? dfr_sel  : reg_sel;
    assign ch_wd[c]   = use_dfr ? dfr_data : reg_wdata;

    irqdma_chan #(.AW(AW), .CW(CW), .VW(VW)) u_chan (
      .clk(clk), .rst_n(rst_i), .wr_en(ch_we[c]), .wr_sel(ch_sel[c]),
      .wr_data(ch_wd[c]), .done(ch_done[c]), .vec(vec_a[c]), .src(src_a[c]),
      .dst(dst_a[c]), .sz(sz_a[c]), .cnt(cnt_a[c]), .tc(tc_irq[c])
    );
  end

  // sources named by an armed channel never reach the interrupt controller
  always_comb begin
    claim = '0;
    for (int s = 1; s < NIRQ; s++)
      for (int c = 0; c < NCH; c++)
        if (vec_a[c] == VW'(s)) claim[s] = 1'b1;
  end
  assign gen_irq = pend & ~claim;

  always_comb begin
    gnt_idx = '0;
    for (int c = 0; c < NCH; c++)
      if (gnt[c]) gnt_idx = CHW'(c);
  end

  assign busy    = (st != ST_IDLE);
  assign accept  = (st == ST_IDLE) && !halt && (|gnt);
  assign done    = (st == ST_WR) && mem_ack;
  assign dma_clr = accept ? (NIRQ'(1) << vec_a[gnt_idx]) : '0;

  // register writes aimed at the channel in service wait in a one-entry slot
  assign queue     = reg_we && ((busy && reg_ch == act_ch) || (dfr_v && reg_ch == dfr_ch));
  assign direct_we = reg_we && !queue;
  assign dfr_apply = dfr_v && (!busy || dfr_ch != act_ch || done);

  always_comb begin
    dfr_v_n    = dfr_v && !dfr_apply;
    dfr_ch_n   = dfr_ch;
    dfr_sel_n  = dfr_sel;
    dfr_data_n = dfr_data;
    if (queue) begin
      dfr_v_n    = 1'b1;
      dfr_ch_n   = reg_ch;
      dfr_sel_n  = reg_sel;
      dfr_data_n = reg_wdata;
    end
  end

  logic [AW-1:0] act_src, act_dst;
  logic [3:0]    act_mask;
  assign act_src  = src_a[act_ch];
  assign act_dst  = dst_a[act_ch];
  assign act_mask = unit_mask(sz_a[act_ch]);

  always_comb begin
    st_n     = st;
    act_ch_n = act_ch;
    data_n   = data_q;
    case (st)
      ST_IDLE: if (accept) begin
        st_n     = ST_RD;
        act_ch_n = gnt_idx;
      end
      ST_RD: if (mem_ack) begin
        st_n   = ST_WR;
        data_n = mem_rdata >> {act_src[1:0], 3'b000};
      end
      ST_WR: if (mem_ack) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st       <= ST_IDLE;
      act_ch   <= '0;
      data_q   <= '0;
      dfr_v    <= 1'b0;
      dfr_ch   <= '0;
      dfr_sel  <= '0;
      dfr_data <= '0;
    end else begin
      st       <= st_n;
      act_ch   <= act_ch_n;
      data_q   <= data_n;
      dfr_v    <= dfr_v_n;
      dfr_ch   <= dfr_ch_n;
      dfr_sel  <= dfr_sel_n;
      dfr_data <= dfr_data_n;
    end
  end

  assign mem_req   = busy;
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = (st == ST_WR) ? {act_dst[AW-1:2], 2'b00} : {act_src[AW-1:2], 2'b00};
  assign mem_be    = (st == ST_WR) ? (act_mask << act_dst[1:0]) : (act_mask << act_src[1:0]);
  assign mem_wdata = data_q << {act_dst[1:0], 3'b000};

  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_IDLE && halt) |=> (st == ST_IDLE));

  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_RD && mem_ack) |=> (mem_req && mem_we));

  a_r5_one_completion: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(tc_irq));

  a_r10_write_held: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_we && busy && reg_ch == act_ch) |=> dfr_v);

endmodule

// File: tb/irq_dma_engine_tb.sv
`timescale 1ns/1ps
module irq_dma_engine_tb;

  logic        clk, rst_n, halt;
  logic [31:0] irq_req, irq_clr, gen_irq;
  logic        reg_we;
  logic [2:0]  reg_ch, reg_sel;
  logic [31:0] reg_wdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [7:0]  tc_irq;

  irq_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .irq_req(irq_req), .irq_clr(irq_clr),
    .gen_irq(gen_irq), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tc_irq(tc_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  logic [7:0]  mb [0:1023];
  int          tc_cnt [8];
  int          req_cyc;
  int          rd_n;
  logic [31:0] rd_log [0:63];

  function automatic logic [7:0] bval(input int a);
    bval = 8'(a) ^ 8'h5A;
  endfunction

  // memory model: one cycle to acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      req_cyc   <= 0;
      rd_n      <= 0;
      for (int i = 0; i < 1024; i++) mb[i] <= (i < 32'h200) ? bval(i) : 8'h00;
      for (int c = 0; c < 8; c++) tc_cnt[c] <= 0;
    end else begin
      for (int c = 0; c < 8; c++) if (tc_irq[c]) tc_cnt[c] <= tc_cnt[c] + 1;
      if (mem_req) req_cyc <= req_cyc + 1;
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= {mb[mem_addr[9:0]+3], mb[mem_addr[9:0]+2], mb[mem_addr[9:0]+1], mb[mem_addr[9:0]]};
        if (mem_we) begin
          for (int k = 0; k < 4; k++) if (mem_be[k]) mb[mem_addr[9:0]+k] <= mem_wdata[8*k +: 8];
        end else begin
          rd_log[rd_n % 64] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 3'(ch); reg_sel = 3'(sel); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic arm(input int ch, input int v, input int sz, input int cnt, input int s, input int d);
    wr_reg(ch, 1, 32'(s));
    wr_reg(ch, 2, 32'(d));
    wr_reg(ch, 3, 32'(sz));
    wr_reg(ch, 4, 32'(cnt));
    wr_reg(ch, 0, 32'(v));
  endtask

  task automatic pulse(input int s);
    @(negedge clk); irq_req[s] = 1'b1;
    @(negedge clk); irq_req[s] = 1'b0;
  endtask

  task automatic ack_gen(input int s);
    @(negedge clk); irq_clr[s] = 1'b1;
    @(negedge clk); irq_clr[s] = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0]  ch;
    logic [4:0]  vec;
    logic [1:0]  sz;
    logic [15:0] cnt;
    logic [9:0]  src;
    logic [9:0]  dst;
  } ent_t;

  localparam ent_t TBL [4] = '{
    '{3'd0, 5'd3,  2'd0, 16'd3, 10'h010, 10'h200},
    '{3'd5, 5'd9,  2'd1, 16'd2, 10'h020, 10'h220},
    '{3'd7, 5'd31, 2'd2, 16'd2, 10'h040, 10'h240},
    '{3'd2, 5'd4,  2'd0, 16'd1, 10'h053, 10'h262}
  };

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int base, nbytes, ok, r0;
    halt = 0; irq_req = '0; irq_clr = '0;
    reg_we = 0; reg_ch = '0; reg_sel = '0; reg_wdata = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R1 reset outputs", {31'b0, mem_req, tc_irq, 8'b0, gen_irq[15:0]}, 32'h0);

    // R1: all channels disarmed, source 0 is forwarded, no transfer
    r0 = req_cyc;
    pulse(0); settle();
    chk("R1 vector 0 forwards", {gen_irq[0], 31'(req_cyc - r0)}, {1'b1, 31'd0});
    ack_gen(0);

    // table of channel programs
    foreach (TBL[e]) begin
      nbytes = (TBL[e].sz == 0) ? 1 : (TBL[e].sz == 1) ? 2 : 4;
      arm(TBL[e].ch, TBL[e].vec, TBL[e].sz, TBL[e].cnt, TBL[e].src, TBL[e].dst);
      base = tc_cnt[TBL[e].ch];
      for (int p = 1; p < int'(TBL[e].cnt); p++) begin pulse(TBL[e].vec); settle(); end
      chk("R4 armed before last unit", {gen_irq[TBL[e].vec], 31'(tc_cnt[TBL[e].ch] - base)}, 32'h0);
      pulse(TBL[e].vec); settle();
      chk("R5 completion pulse", 32'(tc_cnt[TBL[e].ch] - base), 32'd1);
      ok = 1;
      for (int k = 0; k < nbytes * int'(TBL[e].cnt); k++)
        if (mb[int'(TBL[e].dst) + k] !== bval(int'(TBL[e].src) + k)) ok = 0;
      chk("R3 R9 data copied", 32'(ok), 32'd1);
      pulse(TBL[e].vec); settle();
      chk("R8 forwarded after disarm", 32'(gen_irq[TBL[e].vec]), 32'd1);
      ack_gen(TBL[e].vec);
    end

    // R6 and R7: two channels wait under halt, lowest channel goes first
    arm(1, 5, 0, 1, 32'h0A0, 32'h300);
    arm(6, 6, 0, 1, 32'h0B0, 32'h310);
    halt = 1;
    r0 = req_cyc;
    base = rd_n;
    @(negedge clk); irq_req[5] = 1; irq_req[6] = 1;
    @(negedge clk); irq_req[5] = 0; irq_req[6] = 0;
    settle();
    chk("R7 no transfer while halted", 32'(req_cyc - r0), 32'd0);
    chk("R2 claimed requests not forwarded", {30'b0, gen_irq[6], gen_irq[5]}, 32'd0);
    halt = 0;
    settle(); settle();
    chk("R6 lowest channel served first", rd_log[base % 64], 32'h0A0);
    chk("R7 both served after halt", {mb[10'h300], mb[10'h310]}, {16'b0, bval(32'h0A0), bval(32'h0B0)});

    // R11: count 0 means 65536 units
    arm(3, 7, 0, 0, 32'h060, 32'h2C0);
    base = tc_cnt[3];
    for (int p = 0; p < 3; p++) begin pulse(7); settle(); end
    chk("R11 no completion with count 0", {gen_irq[7], 31'(tc_cnt[3] - base)}, 32'h0);
    chk("R11 third unit moved", 32'(mb[10'h2C2]), 32'(bval(32'h062)));

    // R10: destination write during service is held back
    arm(4, 8, 0, 2, 32'h070, 32'h280);
    pulse(8);
    do @(negedge clk); while (!(mem_req && !mem_we));
    reg_we = 1; reg_ch = 3'd4; reg_sel = 3'd2; reg_wdata = 32'h2A0;
    @(negedge clk); reg_we = 0;
    settle();
    chk("R10 unit in flight used old address", {mb[10'h280], mb[10'h2A0]}, {16'b0, bval(32'h070), 8'h00});
    pulse(8); settle();
    chk("R10 held write applied afterwards", 32'(mb[10'h2A0]), 32'(bval(32'h071)));

    // R8/R5 race: new edge on the source in the cycle the last write completes
    arm(0, 12, 0, 1, 32'h014, 32'h2E0);
    base = tc_cnt[0];
    pulse(12);
    do @(negedge clk); while (!(mem_req && mem_we && mem_ack));
    irq_req[12] = 1;
    @(negedge clk); irq_req[12] = 0;
    settle();
    chk("R8 edge at disarm is forwarded", 32'(gen_irq[12]), 32'd1);
    chk("R5 single completion and no extra unit",
        {8'(tc_cnt[0] - base), mb[10'h2E0], mb[10'h2E1], 8'h00},
        {8'd1, bval(32'h014), 8'h00, 8'h00});
    ack_gen(12);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule